// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is an I2C slave that answers to one fixed 7-bit device address and exposes a small bank of 8-bit control registers. A single internal pointer selects the register being accessed. A write frame carries the pointer in its first byte after the address, and the data bytes that follow fill consecutive registers. A read frame streams registers out starting from the pointer. The pointer advances by one after every byte written and after every byte read.

The bus lines are sampled by the system clock. Each line passes through a two-flop synchroniser, and the block looks for edges on the synchronised copies. The system clock must run at sixteen or more times the SCL rate. The slave never drives SDA high. It only enables a pull-down, both for its own acknowledge and for the zero bits of read data. The register contents are presented in parallel to the surrounding logic.

If a read follows a fresh START, it starts from register 0. If a pointer byte has been written and a repeated START follows, the read starts from that pointer instead. Pointer values at or above the bank size are reserved: data written there is acknowledged and then dropped, and reading there returns zero.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After reset every register reads 0x00 and the SDA pull-down is released.
- R2: An address byte whose upper seven bits are 7'b1001101 is acknowledged by pulling SDA low for the whole ninth SCL clock; bit 0 of that byte selects read (1) or write (0). Any other address gets no acknowledge, and the block ignores the bus until the next START.
- R3: In a write frame, the byte after the address loads the pointer. Each following data byte is written to the register the pointer selects, is acknowledged, and then advances the pointer by one.
- R4: With the default five registers, a pointer of 5 or more is reserved. A data byte written there is acknowledged but changes no register, and a byte read from there is 0x00.
- R5: A read that follows a START with no pointer byte written since the last STOP begins at register 0. The pointer then advances after each byte sent.
- R6: A pointer written in a write frame, followed by a repeated START and a read address, makes the read begin at that preset pointer.
- R7: Read bytes are sent MSB first. SDA changes only while SCL is low, so each bit is stable across the SCL high time. A master ACK (SDA low on the ninth clock) continues the stream. A NACK ends it and leaves SDA released.
- R8: A STOP (SDA rising while SCL is high) ends the frame at any bit position: SDA is released and a partly received byte is dropped.
- R9: A STOP that occurs in the same SCL-high period as the START before it is ignored. The frame continues with the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | Registered pull-down enable for the open-drain SDA |
| regs_o | output | NUM_REGS*DATA_W | All registers, register 0 in the low byte |

## Verification
The hardest case to create from the ports is a START and a STOP inside one SCL-high period. No ordinary master sequence produces it. The bench drives the raw lines directly: SDA falls and then rises while SCL stays high, and the bench then clocks a normal address byte. An acknowledge at that point shows the STOP was ignored. A STOP in the middle of a byte and a repeated START after a pointer write are also built with directed line sequences. Random write frames, with pointers that run into the reserved range, are followed by reads from a preset pointer, and both are compared against a bench model of the registers.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } fsm_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } phase_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } bus_evt_t;

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync
  import i2c_rp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_in,
  input  logic     sda_in,
  output bus_evt_t ev
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_prev;
  logic              sda_prev;
  logic              scl_s;
  logic              sda_s;

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= '1;
      sda_q    <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_q    <= {scl_q[STAGES-2:0], scl_in};
      sda_q    <= {sda_q[STAGES-2:0], sda_in};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  always_comb begin
    ev.start = scl_s & scl_prev & sda_prev & ~sda_s;
    ev.stop  = scl_s & scl_prev & ~sda_prev & sda_s;
    ev.rise  = scl_s & ~scl_prev;
    ev.fall  = ~scl_s & scl_prev;
    ev.sda   = sda_s;
  end

endmodule

// File: rtl/i2c_rp_bank.sv
module i2c_rp_bank #(
  parameter int NUM_REGS = 5,
  parameter int DATA_W   = 8,
  parameter int PTR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [PTR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_REGS);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en && (wr_addr < LIMIT)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == PTR_W'(i)) rd_data = mem[i];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = mem[g];
  end

endmodule

// File: rtl/i2c_rp_ctrl.sv
module i2c_rp_ctrl
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001101,
  parameter int         DATA_W   = 8,
  parameter int         PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          ev,
  input  logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_pull,
  output logic              bus_busy
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  fsm_t              state;
  phase_t            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] txsh;
  logic [DATA_W-1:0] nb;
  logic              rw;
  logic              ptr_kept;
  logic              start_hi;
  logic              ack_on;
  logic              mack;

  assign nb = {shreg[DATA_W-2:0], ev.sda};

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      rw       <= 1'b0;
      ptr      <= '0;
      ptr_kept <= 1'b0;
      start_hi <= 1'b0;
      ack_on   <= 1'b0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
      bus_busy <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (ev.fall) start_hi <= 1'b0;
      if (ev.start) begin
        state    <= ST_RX;
        phase    <= PH_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
        bus_busy <= 1'b1;
        start_hi <= 1'b1;
        ack_on   <= 1'b0;
        mack     <= 1'b0;
      end else if (ev.stop && !start_hi) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
        bus_busy <= 1'b0;
        ptr_kept <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: if (ev.rise) begin
            shreg <= nb;
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              state  <= ST_ACK;
              ack_on <= 1'b0;
              unique case (phase)
                PH_ADDR: begin
                  if (nb[DATA_W-1:1] == DEV_ADDR) begin
                    rw <= nb[0];
                    if (nb[0] && !ptr_kept) ptr <= '0;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_PTR: begin
                  ptr      <= PTR_W'(nb);
                  ptr_kept <= 1'b1;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= nb;
                  ptr     <= ptr + 1'b1;
                end
              endcase
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_ACK: if (ev.fall) begin
            if (!ack_on) begin
              ack_on   <= 1'b1;
              sda_pull <= 1'b1;
            end else begin
              ack_on   <= 1'b0;
              sda_pull <= 1'b0;
              if (phase == PH_ADDR && rw) begin
                txsh     <= {rd_data[DATA_W-2:0], 1'b0};
                sda_pull <= ~rd_data[DATA_W-1];
                ptr      <= ptr + 1'b1;
                bitcnt   <= '0;
                state    <= ST_TX;
              end else begin
                state <= ST_RX;
                phase <= (phase == PH_ADDR) ? PH_PTR : PH_DATA;
              end
            end
          end
          ST_TX: if (ev.fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_pull <= 1'b0;
              state    <= ST_TXACK;
            end else begin
              sda_pull <= ~txsh[DATA_W-1];
              txsh     <= {txsh[DATA_W-2:0], 1'b0};
              bitcnt   <= bitcnt + 1'b1;
            end
          end
          ST_TXACK: begin
            if (ev.rise) begin
              if (ev.sda) state <= ST_IDLE;
              else        mack  <= 1'b1;
            end
            if (ev.fall && mack) begin
              mack     <= 1'b0;
              txsh     <= {rd_data[DATA_W-2:0], 1'b0};
              sda_pull <= ~rd_data[DATA_W-1];
              ptr      <= ptr + 1'b1;
              bitcnt   <= '0;
              state    <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1001101,
  parameter int         NUM_REGS    = 5,
  parameter int         DATA_W      = 8,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_in,
  input  logic                       sda_in,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  bus_evt_t          ev;
  logic [PTR_W-1:0]  ptr;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              bus_busy;

  i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
  );

  i2c_rp_ctrl #(.DEV_ADDR(DEV_ADDR), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .ev(ev), .rd_data(rd_data), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_pull(sda_pull_o), .bus_busy(bus_busy)
  );

  i2c_rp_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data), .regs_flat(regs_o)
  );

endmodule

// File: rtl/i2c_rp_checker.sv
module i2c_rp_checker #(
  parameter int NUM_REGS = 5,
  parameter int DATA_W   = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       scl_in,
  input logic                       sda_pull,
  input logic                       bus_busy,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  logic                       started;
  logic [NUM_REGS*DATA_W-1:0] regs_d;
  logic                       pull_d;
  logic [NUM_REGS-1:0]        chg;

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
    regs_d <= regs_flat;
    pull_d <= sda_pull;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
    assign chg[g] = regs_flat[g*DATA_W +: DATA_W] != regs_d[g*DATA_W +: DATA_W];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) $fell(rst) |-> (regs_flat == '0 && !sda_pull)); // R1
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst) (started && sda_pull != pull_d) |-> !scl_in); // R7
  AST_WRITE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst) (started && chg != '0) |-> scl_in); // R3
  AST_ONE_REG_WRITE: assert property (@(posedge clk) disable iff (rst) started |-> $countones(chg) <= 1); // R3
  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (rst) !bus_busy |-> !sda_pull); // R8

endmodule

bind i2c_regptr_slave i2c_rp_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_pull(sda_pull_o),
  .bus_busy(bus_busy), .regs_flat(regs_o)
);

// File: tb/i2c_regptr_slave_bench.sv
module i2c_regptr_slave_bench;

  localparam int NREG = 5;
  localparam int Q    = 8;
  localparam logic [6:0] ADDR = 7'b1001101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mscl = 1'b1;
  logic msda = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] regs;
  logic line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mdl [NREG];
  logic [7:0] buf_b [8];

  always #5 clk = ~clk;

  assign line = msda & ~sda_pull;

  i2c_regptr_slave u_i2c_regptr_slave (
    .clk(clk), .rst(rst), .scl_in(mscl), .sda_in(line),
    .sda_pull_o(sda_pull), .regs_o(regs)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    return (p < NREG) ? mdl[p] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b, output logic r);
    msda = b; waitq();
    mscl = 1'b1; waitq();
    r = line; waitq();
    mscl = 1'b0; waitq();
  endtask

  task automatic do_start();
    msda = 1'b1; waitq();
    mscl = 1'b1; waitq();
    msda = 1'b0; waitq();
    mscl = 1'b0; waitq();
  endtask

  task automatic do_stop();
    msda = 1'b0; waitq();
    mscl = 1'b1; waitq();
    msda = 1'b1; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], r);
    bit_clk(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    logic r;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      bit_clk(1'b1, r);
      b = {b[6:0], r};
    end
    bit_clk(~mack, r);
  endtask

  function automatic logic [39:0] model_flat();
    logic [39:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  task automatic write_frame(input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] q;
    q = p;
    do_start();
    send_byte({ADDR, 1'b0}, ack); chk("R2 addr ack", ack, 1'b1);
    send_byte(p, ack);            chk("R3 ptr ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      send_byte(buf_b[i], ack);
      chk((q < NREG) ? "R3 data ack" : "R4 reserved ack", ack, 1'b1);
      if (q < NREG) mdl[q] = buf_b[i];
      q = q + 8'd1;
    end
    do_stop();
    chk("R3 regs after write", regs, model_flat());
  endtask

  task automatic read_frame(input bit preset, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] q;
    logic [7:0] b;
    do_start();
    if (preset) begin
      send_byte({ADDR, 1'b0}, ack); chk("R6 addr ack", ack, 1'b1);
      send_byte(p, ack);            chk("R6 ptr ack", ack, 1'b1);
      do_start();
      q = p;
    end else begin
      q = 8'd0;
    end
    send_byte({ADDR, 1'b1}, ack); chk("R2 read addr ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      read_byte(i != n - 1, b);
      if (q >= NREG)   chk("R4 reserved read", b, 8'h00);
      else if (preset) chk("R6 preset read", b, exp_rd(q));
      else             chk("R5 read from zero", b, exp_rd(q));
      q = q + 8'd1;
    end
    chk("R7 released after NACK", sda_pull, 1'b0);
    do_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic r;
    logic [7:0] b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 regs after reset", regs, 40'h0);
    chk("R1 pull after reset", sda_pull, 1'b0);

    // R2: foreign address, then more bytes are ignored
    do_start();
    send_byte({7'b1001100, 1'b0}, ack); chk("R2 wrong addr nack", ack, 1'b0);
    send_byte(8'h01, ack);              chk("R2 ignored byte nack", ack, 1'b0);
    send_byte(8'hA5, ack);              chk("R2 ignored data nack", ack, 1'b0);
    do_stop();
    chk("R2 regs untouched", regs, 40'h0);

    // R3: multi-byte autoincrement
    buf_b[0] = 8'h11; buf_b[1] = 8'h22; buf_b[2] = 8'h33;
    write_frame(8'd1, 3);
    // R4: write crossing into reserved range
    buf_b[0] = 8'h44; buf_b[1] = 8'hEE; buf_b[2] = 8'hFF;
    write_frame(8'd4, 3);
    // R5: fresh START read streams from 0, into reserved area
    read_frame(1'b0, 8'd0, 7);
    // R6: preset pointer read
    read_frame(1'b1, 8'd2, 3);

    // R7: read bits are stable across SCL high
    do_start();
    send_byte({ADDR, 1'b1}, ack); chk("R7 addr ack", ack, 1'b1);
    begin
      logic stable;
      stable = 1'b1;
      b = 8'h00;
      for (int i = 0; i < 8; i++) begin
        msda = 1'b1; waitq();
        mscl = 1'b1; waitq();
        r = line;
        repeat (Q) begin
          @(negedge clk);
          if (line !== r) stable = 1'b0;
        end
        mscl = 1'b0; waitq();
        b = {b[6:0], r};
      end
      chk("R7 bit stable in high", stable, 1'b1);
      chk("R7 msb first data", b, exp_rd(8'd0));
      bit_clk(1'b1, r);
    end
    do_stop();

    // R8: STOP in the middle of a data byte
    do_start();
    send_byte({ADDR, 1'b0}, ack); chk("R8 addr ack", ack, 1'b1);
    send_byte(8'd0, ack);         chk("R8 ptr ack", ack, 1'b1);
    bit_clk(1'b0, r); bit_clk(1'b1, r); bit_clk(1'b0, r);
    do_stop();
    chk("R8 pull released", sda_pull, 1'b0);
    chk("R8 partial byte dropped", regs, model_flat());
    read_frame(1'b0, 8'd0, 2);

    // R9: START and STOP in one SCL-high period
    msda = 1'b1; waitq();
    mscl = 1'b1; waitq();
    msda = 1'b0; waitq();
    msda = 1'b1; waitq();
    mscl = 1'b0; waitq();
    send_byte({ADDR, 1'b0}, ack); chk("R9 stop ignored, addr ack", ack, 1'b1);
    send_byte(8'd2, ack);         chk("R9 ptr ack", ack, 1'b1);
    send_byte(8'h5A, ack);        chk("R9 data ack", ack, 1'b1);
    mdl[2] = 8'h5A;
    do_stop();
    chk("R9 write landed", regs, model_flat());

    // Random frames: R3 R4 R6
    for (int it = 0; it < 14; it++) begin
      int n;
      logic [7:0] p;
      p = 8'($urandom_range(0, 6));
      n = $urandom_range(1, 3);
      for (int i = 0; i < n; i++) buf_b[i] = 8'($urandom);
      write_frame(p, n);
      read_frame(1'b1, 8'($urandom_range(0, 5)), $urandom_range(1, 3));
    end
    read_frame(1'b0, 8'd0, 5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule